// File: doc/BRIEF.md
# MSI Target Address Composer

This block turns an interrupt delivery request into the 64-bit target address and the 11-bit identity word of a message-signalled interrupt write. A request carries a 14-bit hart index, a 6-bit guest index, an identity and a level flag. The hart index is split into a group part and a local part by two programmable widths. Each part is placed at a programmable shift inside a page number. That page number is ORed onto a 44-bit base and then shifted up by 12 to give a byte address.

Two configuration register pairs hold the base and the layout: one pair for machine-level delivery and one for supervisor-level delivery. Each pair has a low word and a high word. A lock bit in the machine high word freezes all four words until reset. The supervisor pair is present only when the parameter `CHILD_CNT` is non-zero.

Software can also write a generate word to launch a message directly. The stored copy of that word is readable. The finished address and identity are held in an output register and handed off through a valid/ready handshake to the logic that performs the bus write.

Top module: `msi_addr_composer`

## Requirements
- R1: After reset, `out_valid_o` is 0, `req_ready_o` is 1, `gen_value_o` is 0 and all four configuration words read 0.
- R2: Configuration select codes are 0 machine low, 1 machine high, 2 supervisor low and 3 supervisor high. A low word stores all 32 bits. A high word keeps only bits 31, 28:24, 22:20, 18:16, 15:12 and 11:0, so the stored value is the written value AND 0x9F77FFFF.
- R3: The high-word fields are: lock at bit 31, group shift GS at 28:24, local shift LS at 22:20, group width GW at 18:16, local width LW at 15:12 and base upper bits at 11:0. With hart index H, the local part is H masked to LW bits and the group part is H shifted right by LW. The address is (base | ((group masked to GW bits) << (GS+12)) | (local << LS) | guest term) << 12, where base is {high[11:0], low}.
- R4: The guest term is the guest index masked to LS bits.
- R5: When `req_smode_i` is 0, the machine pair is used and the guest index is forced to 0. When it is 1, the supervisor pair is used and the guest index is applied.
- R6: Once the machine high word has bit 31 set, writes to any of the four configuration words are ignored.
- R7: With `CHILD_CNT` = 0, the supervisor pair reads 0 and writes to it have no effect.
- R8: A write to the generate word stores the value with bits 17:12 cleared on `gen_value_o`. It then issues one message that uses hart index = bits 31:18, guest 0, identity = bits 10:0 and the machine pair.
- R9: A pending generated message is issued before any queued request. `req_ready_o` stays 0 while it is pending.
- R10: A request accepted on an edge (valid and ready both high) appears on `out_valid_o`, `out_addr_o` and `out_eiid_o` right after that edge.
- R11: While `out_valid_o` is 1 and `out_ready_i` is 0, the address and identity stay stable, `out_valid_o` stays 1 and `req_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration word to write |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rsel_i | input | 2 | Configuration word to read |
| cfg_rdata_o | output | 32 | Configuration read data |
| gen_we_i | input | 1 | Generate-word write strobe |
| gen_wdata_i | input | 32 | Generate-word write data |
| gen_value_o | output | 32 | Stored generate word |
| req_valid_i | input | 1 | Delivery request valid |
| req_ready_o | output | 1 | Delivery request accepted |
| req_smode_i | input | 1 | 1 selects supervisor-level delivery |
| req_hart_i | input | 14 | Target hart index |
| req_guest_i | input | 6 | Target guest index |
| req_eiid_i | input | 11 | Interrupt identity |
| out_valid_o | output | 1 | Composed message valid |
| out_ready_i | input | 1 | Downstream accepts message |
| out_addr_o | output | 64 | Message target address |
| out_eiid_o | output | 11 | Message data (identity) |

## Verification
The composer is driven with hart indices whose group and local parts land in different bit ranges, under layouts that differ in width and shift. This shows whether the split point, the group mask and each placement shift are right. Supervisor requests carry guest indices wider than the local shift, which exposes a missing guest mask. They also use a different base, which exposes a wrong pair selection. Machine requests carry non-zero guests, which exposes a guest that was not forced to zero. Backpressure sequences hold the output while inputs change and race a generated write against a queued request, which checks the hold behaviour and the issue order.

// File: rtl/msi_comp_pkg.sv
package msi_comp_pkg;
  localparam int HART_W  = 14;
  localparam int GUEST_W = 6;
  localparam int EIID_W  = 11;
  localparam int ADDR_W  = 64;
  localparam int WORD_W  = 32;
  localparam int PAGE_SH = 12;

  localparam logic [WORD_W-1:0] HI_KEEP  = 32'h9F77_FFFF;
  localparam logic [WORD_W-1:0] GEN_KEEP = 32'hFFFC_0FFF;

  typedef enum logic [1:0] {
    CFG_M_LO = 2'd0,
    CFG_M_HI = 2'd1,
    CFG_S_LO = 2'd2,
    CFG_S_HI = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_comp_pkg::*;
#(
  parameter int CHILD_CNT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [1:0]        rsel_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WORD_W-1:0] m_lo_o,
  output logic [WORD_W-1:0] m_hi_o,
  output logic [WORD_W-1:0] s_lo_o,
  output logic [WORD_W-1:0] s_hi_o
);
  logic [WORD_W-1:0] m_lo_q, m_hi_q;
  logic              wr_ok;

  assign wr_ok = we_i & ~m_hi_q[31];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lo_q <= '0;
      m_hi_q <= '0;
    end else if (wr_ok) begin
      if (sel_i == CFG_M_LO) m_lo_q <= wdata_i;
      if (sel_i == CFG_M_HI) m_hi_q <= wdata_i & HI_KEEP;
    end
  end

  generate
    if (CHILD_CNT > 0) begin : g_s_pair
      logic [WORD_W-1:0] s_lo_q, s_hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s_lo_q <= '0;
          s_hi_q <= '0;
        end else if (wr_ok) begin
          if (sel_i == CFG_S_LO) s_lo_q <= wdata_i;
          if (sel_i == CFG_S_HI) s_hi_q <= wdata_i & HI_KEEP;
        end
      end
      assign s_lo_o = s_lo_q;
      assign s_hi_o = s_hi_q;
    end else begin : g_no_s_pair
      assign s_lo_o = '0;
      assign s_hi_o = '0;
    end
  endgenerate

  assign m_lo_o = m_lo_q;
  assign m_hi_o = m_hi_q;

  always_comb begin
    unique case (rsel_i)
      CFG_M_LO: rdata_o = m_lo_q;
      CFG_M_HI: rdata_o = m_hi_q;
      CFG_S_LO: rdata_o = s_lo_o;
      default:  rdata_o = s_hi_o;
    endcase
  end
endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc
  import msi_comp_pkg::*;
(
  input  logic [WORD_W-1:0]  lo_i,
  input  logic [WORD_W-1:0]  hi_i,
  input  logic [HART_W-1:0]  hart_i,
  input  logic [GUEST_W-1:0] guest_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [4:0]  grp_sh;
  logic [2:0]  loc_sh;
  logic [2:0]  grp_w;
  logic [3:0]  loc_w;
  logic [11:0] base_hi;
  logic [3:0]  unused_hi_bits;

  logic [ADDR_W-1:0] hart_x, grp_idx, loc_idx, grp_msk, loc_msk, gst_msk;
  logic [ADDR_W-1:0] base, grp_t, loc_t, gst_t, ppn;

  assign grp_sh  = hi_i[28:24];
  assign loc_sh  = hi_i[22:20];
  assign grp_w   = hi_i[18:16];
  assign loc_w   = hi_i[15:12];
  assign base_hi = hi_i[11:0];
  assign unused_hi_bits = {hi_i[31], hi_i[29], hi_i[23], hi_i[19]};

  always_comb begin
    hart_x  = {{(ADDR_W-HART_W){1'b0}}, hart_i};
    loc_msk = (64'd1 << loc_w) - 64'd1;
    grp_msk = (64'd1 << grp_w) - 64'd1;
    gst_msk = (64'd1 << loc_sh) - 64'd1;
    grp_idx = hart_x >> loc_w;
    loc_idx = hart_x & loc_msk;
    base    = {{(ADDR_W-44){1'b0}}, base_hi, lo_i};
    grp_t   = (grp_idx & grp_msk) << ({1'b0, grp_sh} + 6'd12);
    loc_t   = loc_idx << loc_sh;
    gst_t   = {{(ADDR_W-GUEST_W){1'b0}}, guest_i} & gst_msk;
    ppn     = base | grp_t | loc_t | gst_t;
    addr_o  = ppn << PAGE_SH;
  end
endmodule

// File: rtl/msi_out_stage.sv
module msi_out_stage
  import msi_comp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EIID_W-1:0] eiid_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [EIID_W-1:0] eiid_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [EIID_W-1:0] eiid_q;

  assign free_o = ~valid_q | ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      eiid_q  <= '0;
    end else if (free_o) begin
      valid_q <= load_i;
      if (load_i) begin
        addr_q <= addr_i;
        eiid_q <= eiid_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign eiid_o  = eiid_q;
endmodule

// File: rtl/msi_addr_composer.sv
module msi_addr_composer
  import msi_comp_pkg::*;
#(
  parameter int CHILD_CNT = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [WORD_W-1:0]  cfg_wdata_i,
  input  logic [1:0]         cfg_rsel_i,
  output logic [WORD_W-1:0]  cfg_rdata_o,
  input  logic               gen_we_i,
  input  logic [WORD_W-1:0]  gen_wdata_i,
  output logic [WORD_W-1:0]  gen_value_o,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_smode_i,
  input  logic [HART_W-1:0]  req_hart_i,
  input  logic [GUEST_W-1:0] req_guest_i,
  input  logic [EIID_W-1:0]  req_eiid_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [ADDR_W-1:0]  out_addr_o,
  output logic [EIID_W-1:0]  out_eiid_o
);
  logic [WORD_W-1:0]  m_lo, m_hi, s_lo, s_hi;
  logic [WORD_W-1:0]  gen_q;
  logic               gen_pend_q;
  logic               slot_free, issue_gen, issue_req, use_m;
  logic [WORD_W-1:0]  sel_lo, sel_hi;
  logic [HART_W-1:0]  sel_hart;
  logic [GUEST_W-1:0] sel_guest;
  logic [EIID_W-1:0]  sel_eiid;
  logic [ADDR_W-1:0]  calc_addr;

  msi_cfg_regs #(.CHILD_CNT(CHILD_CNT)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rsel_i  (cfg_rsel_i),
    .rdata_o (cfg_rdata_o),
    .m_lo_o  (m_lo),
    .m_hi_o  (m_hi),
    .s_lo_o  (s_lo),
    .s_hi_o  (s_hi)
  );

  // generated write waits here until the output slot frees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q      <= '0;
      gen_pend_q <= 1'b0;
    end else if (gen_we_i) begin
      gen_q      <= gen_wdata_i & GEN_KEEP;
      gen_pend_q <= 1'b1;
    end else if (issue_gen) begin
      gen_pend_q <= 1'b0;
    end
  end

  assign issue_gen   = gen_pend_q & slot_free;
  assign req_ready_o = slot_free & ~gen_pend_q;
  assign issue_req   = req_valid_i & req_ready_o;

  assign use_m     = gen_pend_q | ~req_smode_i;
  assign sel_lo    = use_m ? m_lo : s_lo;
  assign sel_hi    = use_m ? m_hi : s_hi;
  assign sel_hart  = gen_pend_q ? gen_q[31:18] : req_hart_i;
  assign sel_guest = use_m ? '0 : req_guest_i;
  assign sel_eiid  = gen_pend_q ? gen_q[10:0] : req_eiid_i;

  msi_addr_calc u_calc (
    .lo_i    (sel_lo),
    .hi_i    (sel_hi),
    .hart_i  (sel_hart),
    .guest_i (sel_guest),
    .addr_o  (calc_addr)
  );

  msi_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (issue_gen | issue_req),
    .addr_i  (calc_addr),
    .eiid_i  (sel_eiid),
    .ready_i (out_ready_i),
    .free_o  (slot_free),
    .valid_o (out_valid_o),
    .addr_o  (out_addr_o),
    .eiid_o  (out_eiid_o)
  );

  assign gen_value_o = gen_q;
endmodule

// File: rtl/msi_addr_composer_chk.sv
module msi_addr_composer_chk
  import msi_comp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [EIID_W-1:0] out_eiid_o,
  input logic [WORD_W-1:0] m_lo,
  input logic [WORD_W-1:0] m_hi,
  input logic [WORD_W-1:0] s_lo,
  input logic [WORD_W-1:0] s_hi
);
  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(out_valid_o && !out_ready_i) |->
      out_valid_o && $stable(out_addr_o) && $stable(out_eiid_o));

  // R11
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !req_ready_o);

  // R6
  lock_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(m_hi[31]) |->
      $stable(m_lo) && $stable(m_hi) && $stable(s_lo) && $stable(s_hi));

  // R10
  accept_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && req_ready_o) |-> out_valid_o);

  // R2
  hi_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_hi & ~HI_KEEP) == '0 && (s_hi & ~HI_KEEP) == '0);
endmodule

bind msi_addr_composer msi_addr_composer_chk chk_i (.*);

// File: tb/msi_addr_composer_tb_top.sv
module msi_addr_composer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0, cfg_rsel = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, nc_rdata;
  logic        gen_we = 1'b0;
  logic [31:0] gen_wdata = '0, gen_value, nc_gen;
  logic        req_valid = 1'b0, req_ready, nc_ready;
  logic        req_smode = 1'b0;
  logic [13:0] req_hart = '0;
  logic [5:0]  req_guest = '0;
  logic [10:0] req_eiid = '0;
  logic        out_valid, nc_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_addr, nc_addr;
  logic [10:0] out_eiid, nc_eiid;

  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;

  msi_addr_composer #(.CHILD_CNT(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rsel_i(cfg_rsel), .cfg_rdata_o(cfg_rdata),
    .gen_we_i(gen_we), .gen_wdata_i(gen_wdata), .gen_value_o(gen_value),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_smode_i(req_smode),
    .req_hart_i(req_hart), .req_guest_i(req_guest), .req_eiid_i(req_eiid),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_addr_o(out_addr),
    .out_eiid_o(out_eiid));

  msi_addr_composer #(.CHILD_CNT(0)) dut_nc_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rsel_i(cfg_rsel), .cfg_rdata_o(nc_rdata),
    .gen_we_i(gen_we), .gen_wdata_i(gen_wdata), .gen_value_o(nc_gen),
    .req_valid_i(req_valid), .req_ready_o(nc_ready), .req_smode_i(req_smode),
    .req_hart_i(req_hart), .req_guest_i(req_guest), .req_eiid_i(req_eiid),
    .out_valid_o(nc_valid), .out_ready_i(out_ready), .out_addr_o(nc_addr),
    .out_eiid_o(nc_eiid));

  // bench-side copies of the configuration words
  logic [31:0] m_lo_m = '0, m_hi_m = '0, s_lo_m = '0, s_hi_m = '0;

  function automatic logic [63:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                        input logic [13:0] hart, input logic [5:0] guest);
    int gs, ls, gw, lw;
    logic [63:0] grp, loc, pn;
    gs  = int'(hi[28:24]);
    ls  = int'(hi[22:20]);
    gw  = int'(hi[18:16]);
    lw  = int'(hi[15:12]);
    loc = 64'(hart) % (64'd1 << lw);
    grp = (64'(hart) / (64'd1 << lw)) % (64'd1 << gw);
    pn  = {20'd0, hi[11:0], lo};
    pn  = pn | (grp << (gs + 12)) | (loc << ls) | (64'(guest) % (64'd1 << ls));
    return pn << 12;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
    @(negedge clk);
    cfg_rsel = sel;
    #1 check(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic pop();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic send_chk(input string req, input logic smode, input logic [13:0] hart,
                          input logic [5:0] guest, input logic [10:0] eiid);
    logic [63:0] exp;
    exp = smode ? model(s_lo_m, s_hi_m, hart, guest) : model(m_lo_m, m_hi_m, hart, 6'd0);
    @(negedge clk);
    req_valid = 1'b1; req_smode = smode; req_hart = hart; req_guest = guest; req_eiid = eiid;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " addr"}, out_addr, exp);
    check({req, " eiid"}, 64'(out_eiid), 64'(eiid));
    pop();
  endtask

  task automatic t_reset();
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 gen_value", 64'(gen_value), 64'd0);
    for (int k = 0; k < 4; k++) cfg_rd_chk("R1 cfg word", 2'(k), 32'd0);
  endtask

  task automatic t_mask();
    cfg_wr(2'd0, 32'hDEAD_BEEF);
    cfg_wr(2'd1, 32'h7FFF_FFFF);
    cfg_rd_chk("R2 low word", 2'd0, 32'hDEAD_BEEF);
    cfg_rd_chk("R2 high word mask", 2'd1, 32'h1F77_FFFF);
    cfg_wr(2'd3, 32'h6AAA_5555);
    cfg_rd_chk("R2 s high mask", 2'd3, 32'h6AAA_5555 & 32'h9F77_FFFF);
  endtask

  task automatic t_split();
    m_lo_m = 32'h0008_0000;
    m_hi_m = (32'd5 << 24) | (32'd2 << 20) | (32'd3 << 16) | (32'd4 << 12) | 32'h00A;
    cfg_wr(2'd0, m_lo_m);
    cfg_wr(2'd1, m_hi_m);
    send_chk("R3 split a", 1'b0, 14'h0B7, 6'h00, 11'h123);
    send_chk("R5 machine guest forced", 1'b0, 14'h3FFF, 6'h3F, 11'h7FF);
    m_hi_m = (32'd17 << 24) | (32'd0 << 20) | (32'd7 << 16) | (32'd9 << 12) | 32'hF01;
    cfg_wr(2'd1, m_hi_m);
    send_chk("R3 split b", 1'b0, 14'h2A5C, 6'h15, 11'h001);
  endtask

  task automatic t_guest();
    s_lo_m = 32'h1234_5000;
    s_hi_m = (32'd9 << 24) | (32'd3 << 20) | (32'd2 << 16) | (32'd1 << 12) | 32'h0C0;
    cfg_wr(2'd2, s_lo_m);
    cfg_wr(2'd3, s_hi_m);
    send_chk("R4 guest mask", 1'b1, 14'h0007, 6'h3D, 11'h055);
    send_chk("R5 supervisor pair", 1'b1, 14'h1002, 6'h02, 11'h400);
  endtask

  task automatic t_nochild();
    @(negedge clk);
    cfg_rsel = 2'd2;
    #1 check("R7 no child s low", 64'(nc_rdata), 64'd0);
    cfg_rsel = 2'd3;
    #1 check("R7 no child s high", 64'(nc_rdata), 64'd0);
    cfg_rsel = 2'd0;
    #1 check("R7 no child m low", 64'(nc_rdata), 64'(m_lo_m));
  endtask

  task automatic t_hold();
    logic [63:0] exp;
    exp = model(m_lo_m, m_hi_m, 14'h0155, 6'd0);
    @(negedge clk);
    req_valid = 1'b1; req_smode = 1'b0; req_hart = 14'h0155; req_eiid = 11'h0AA;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 next-cycle valid", 64'(out_valid), 64'd1);
    for (int k = 0; k < 3; k++) begin
      req_hart = req_hart + 14'd7; req_eiid = req_eiid + 11'd3; req_valid = 1'b1;
      @(negedge clk);
      check("R11 addr held", out_addr, exp);
      check("R11 ready low", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    check("R11 eiid held", 64'(out_eiid), 64'h0AA);
    pop();
    check("R11 drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_gen();
    logic [31:0] v;
    v = {14'h00C3, 6'h3F, 1'b1, 11'h2B4};
    @(negedge clk);
    gen_we = 1'b1; gen_wdata = v;
    @(negedge clk);
    gen_we = 1'b0;
    check("R8 stored value", 64'(gen_value), 64'(v & 32'hFFFC_0FFF));
    @(negedge clk);
    check("R8 issued", 64'(out_valid), 64'd1);
    check("R8 addr", out_addr, model(m_lo_m, m_hi_m, v[31:18], 6'd0));
    check("R8 eiid", 64'(out_eiid), 64'(v[10:0]));
    pop();
  endtask

  task automatic t_prio();
    logic [31:0] v;
    v = {14'h0011, 6'h00, 1'b0, 11'h321};
    @(negedge clk);
    req_valid = 1'b1; req_smode = 1'b0; req_hart = 14'h0001; req_eiid = 11'h010;
    @(negedge clk);
    gen_we = 1'b1; gen_wdata = v;
    req_hart = 14'h0002; req_eiid = 11'h020;
    @(negedge clk);
    gen_we = 1'b0;
    check("R9 ready low while pending", 64'(req_ready), 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R9 generated first", 64'(out_eiid), 64'h321);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0; req_valid = 1'b0;
    check("R9 request second", 64'(out_eiid), 64'h020);
    check("R9 request addr", out_addr, model(m_lo_m, m_hi_m, 14'h0002, 6'd0));
    pop();
  endtask

  task automatic t_lock();
    m_hi_m = 32'h8000_0000 | (32'd1 << 12) | 32'h003;
    cfg_wr(2'd1, m_hi_m);
    cfg_wr(2'd0, 32'hFFFF_FFFF);
    cfg_wr(2'd1, 32'h0000_0000);
    cfg_wr(2'd2, 32'h0BAD_0BAD);
    cfg_wr(2'd3, 32'h0000_0000);
    cfg_rd_chk("R6 m low frozen", 2'd0, m_lo_m);
    cfg_rd_chk("R6 m high frozen", 2'd1, m_hi_m);
    cfg_rd_chk("R6 s low frozen", 2'd2, s_lo_m);
    cfg_rd_chk("R6 s high frozen", 2'd3, s_hi_m);
    send_chk("R6 locked layout used", 1'b0, 14'h0003, 6'd0, 11'h00F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_split();
    t_guest();
    t_nochild();
    t_hold();
    t_gen();
    t_prio();
    t_lock();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule